// File: doc/BRIEF.md
# Real-Time Clock Serial-Link Target

This block sits at the far end of a three-wire serial link: an enable line, a serial clock and a data input, plus one data output back to the master. Behind the link it keeps a bank of eight 32-bit registers. One of them is a seconds counter that advances on every pulse of a 1 Hz tick input. The master writes a register by shifting in 32 data bits, then 3 address bits, and then dropping enable and clocking a mode bit of 1. It reads a register by shifting in 3 address bits and then clocking a mode bit of 0 with enable low. It then clocks 32 more pulses and samples one returned bit after each falling edge, most significant bit first.

All link inputs pass through a synchroniser into the system clock domain. The framing runs as a four-state machine:
- IDLE waits for a rising edge on enable (transition start, to SHIFT).
- SHIFT collects bits on each serial-clock rise while enable is high. A rise with enable low is the mode bit. A mode bit of 1 leads to commit, back to IDLE; a mode bit of 0 leads to arm, to ARM.
- ARM waits for the falling edge of the mode pulse (transition present, to SEND).
- SEND moves one register bit out per falling edge. After the 32nd bit it returns to IDLE (transition drain).

A ready-reset pulse forces IDLE from any state (transition abort). The ready output is high exactly in IDLE.

Top module: `rtc_link_target`

## Requirements
- R1: After reset, ready is 1, data-out is 0 and all eight registers read back as 0.
- R2: A write frame commits its 32 data bits into the register selected by its 3 address bits. Both fields are sent most significant bit first, data before address, and the frame ends with a mode bit of 1 clocked while enable is low.
- R3: A read frame consists of 3 address bits, then a mode bit of 0 clocked while enable is low. The addressed register then appears on data-out most significant bit first, with one new bit after each falling edge of the following 32 clock pulses.
- R4: Serial-clock pulses while the link is idle and enable is low change no register and leave ready at 1.
- R5: A write frame that carried fewer than 35 bits before its mode bit commits nothing, and ready returns to 1.
- R6: A write frame that carried more than 35 bits uses only the last 35: the top 32 as data and the low 3 as address.
- R7: Ready is 0 from a rising edge of enable until the frame ends. A write ends at its mode bit; a read ends after the 32nd returned bit.
- R8: A ready-reset pulse aborts any frame in progress: ready is 1 and data-out is 0 on the next cycle, and the aborted write commits nothing.
- R9: The seconds counter (address 0) increments by one per tick, wrapping from all ones to zero.
- R10: When a write to the seconds counter commits in the same cycle as a tick, the written value is stored and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_en | input | 1 | Link enable from the master |
| link_sclk | input | 1 | Serial clock from the master |
| link_sdi | input | 1 | Serial data from the master |
| link_sdo | output | 1 | Serial data to the master |
| link_ready | output | 1 | High while the link is idle and can accept a frame |
| ready_rst | input | 1 | One-cycle pulse that aborts the frame and forces idle |
| sec_tick | input | 1 | One-cycle pulse per second that advances the counter |

## Verification
The hardest case to reach is a counter write committing in the very cycle of a tick, because the commit lands several system clocks after the mode-bit clock rise, behind the synchroniser. The bench does not rely on that exact latency. It repeats the counter write six times and moves the tick one cycle later each time across the high phase of the mode pulse, so one repetition hits the commit cycle. Each result must be the written value or one more than it, never the old count plus one. Short, overlong and aborted frames are built bit by bit, and their effect is read back through normal read frames.

// File: rtl/rtc_link_pkg.sv
package rtc_link_pkg;
    typedef enum logic [1:0] {
        L_IDLE  = 2'd0,
        L_SHIFT = 2'd1,
        L_ARM   = 2'd2,
        L_SEND  = 2'd3
    } link_state_t;
endpackage

// File: rtl/rtc_link_sync.sv
module rtc_link_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3,
    parameter int SEC_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NREGS = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] SEC_A = ADDR_W'(SEC_ADDR);

    logic [NREGS-1:0][DATA_W-1:0] bank;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(g);
        logic [DATA_W-1:0] val;
        logic              hit;
        assign hit = wr_en && (wr_addr == MY_A);
        if (g == SEC_ADDR) begin : g_sec
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    val <= '0;
                else if (hit)  val <= wr_data;
                else if (tick) val <= val + 1'b1;
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   val <= '0;
                else if (hit) val <= wr_data;
            end
        end
        assign bank[g] = val;
    end

    assign rd_data = bank[rd_addr];

    // R10
    counter_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SEC_A && tick) |=> bank[SEC_A] == $past(wr_data));

    // R9
    sec_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(wr_en && wr_addr == SEC_A)) |=> bank[SEC_A] == $past(bank[SEC_A]) + DATA_W'(1));

    // R2
    write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bank[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/rtc_link_fsm.sv
module rtc_link_fsm
    import rtc_link_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_rst,
    input  logic              en,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              ready,
    output logic              sdo
);
    localparam int FRAME_W = DATA_W + ADDR_W;
    localparam int BCNT_W  = $clog2(FRAME_W + 1);
    localparam int OCNT_W  = $clog2(DATA_W + 1);

    link_state_t        state, state_nx;
    logic               en_d, sclk_d;
    logic               en_rise, sclk_rise, sclk_fall;
    logic [FRAME_W-1:0] shreg;
    logic [BCNT_W-1:0]  bcnt;
    logic               full;
    logic [DATA_W-1:0]  osh;
    logic [OCNT_W-1:0]  ocnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_d   <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            en_d   <= en;
            sclk_d <= sclk;
        end
    end

    assign en_rise   = en && !en_d;
    assign sclk_rise = sclk && !sclk_d;
    assign sclk_fall = !sclk && sclk_d;
    assign full      = (bcnt == BCNT_W'(FRAME_W));
    assign rd_addr   = shreg[ADDR_W-1:0];
    assign ready     = (state == L_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= L_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (ready_rst) begin
            state_nx = L_IDLE;
        end else begin
            unique case (state)
                L_IDLE:  if (en_rise) state_nx = L_SHIFT;
                L_SHIFT: if (sclk_rise && !en) state_nx = sdi ? L_IDLE : L_ARM;
                L_ARM:   if (sclk_fall) state_nx = L_SEND;
                L_SEND:  if (sclk_fall && ocnt == OCNT_W'(DATA_W - 1)) state_nx = L_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bcnt    <= '0;
            osh     <= '0;
            ocnt    <= '0;
            sdo     <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ready_rst) begin
                shreg <= '0;
                bcnt  <= '0;
                ocnt  <= '0;
                sdo   <= 1'b0;
            end else begin
                unique case (state)
                    L_IDLE: begin
                        if (en_rise) begin
                            shreg <= '0;
                            bcnt  <= '0;
                            sdo   <= 1'b0;
                        end
                    end
                    L_SHIFT: begin
                        if (sclk_rise) begin
                            if (en) begin
                                shreg <= {shreg[FRAME_W-2:0], sdi};
                                if (!full) bcnt <= bcnt + 1'b1;
                            end else if (sdi) begin
                                wr_en   <= full;
                                wr_addr <= shreg[ADDR_W-1:0];
                                wr_data <= shreg[FRAME_W-1:ADDR_W];
                            end else begin
                                osh  <= rd_data;
                                ocnt <= '0;
                            end
                        end
                    end
                    L_ARM: begin
                        ocnt <= '0;
                    end
                    L_SEND: begin
                        if (sclk_fall) begin
                            sdo  <= osh[DATA_W-1];
                            osh  <= {osh[DATA_W-2:0], 1'b0};
                            ocnt <= ocnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R8
    ready_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_rst |=> (ready && !sdo));

    // R4
    idle_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == L_IDLE) |=> !wr_en);

    // R5
    short_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(full));

    // R3
    send_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == L_SEND) |-> (ocnt < OCNT_W'(DATA_W)));
endmodule

// File: rtl/rtc_link_target.sv
module rtc_link_target #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 3,
    parameter int SEC_ADDR    = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_en,
    input  logic link_sclk,
    input  logic link_sdi,
    output logic link_sdo,
    output logic link_ready,
    input  logic ready_rst,
    input  logic sec_tick
);
    logic [2:0]        sync_q;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    rtc_link_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({link_en, link_sclk, link_sdi}),
        .q     (sync_q)
    );

    rtc_link_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_rst (ready_rst),
        .en        (sync_q[2]),
        .sclk      (sync_q[1]),
        .sdi       (sync_q[0]),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ready     (link_ready),
        .sdo       (link_sdo)
    );

    rtc_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEC_ADDR(SEC_ADDR)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sec_tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: tb/sim_rtc_link_target.sv
`timescale 1ns/1ps
module sim_rtc_link_target;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, sclk = 1'b0, sdi = 1'b0, rrst = 1'b0, tick = 1'b0;
    logic sdo, rdy;
    int   n_chk = 0, n_bad = 0;
    logic [31:0] model [8];

    always #4 clk = ~clk;

    rtc_link_target u0 (
        .clk(clk), .rst_n(rst_n), .link_en(en), .link_sclk(sclk), .link_sdi(sdi),
        .link_sdo(sdo), .link_ready(rdy), .ready_rst(rrst), .sec_tick(tick)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        sdi = b; wait_n(4);
        sclk = 1'b1; wait_n(6);
        sclk = 1'b0; wait_n(6);
    endtask

    task automatic send_bits(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    task automatic write_frame(input logic [63:0] v, input int n);
        en = 1'b1; wait_n(6);
        send_bits(v, n);
        en = 1'b0; wait_n(4);
        pulse(1'b1);
        sdi = 1'b0; wait_n(4);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        write_frame(64'({d, a}), 35);
        model[a] = d;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        en = 1'b1; wait_n(6);
        send_bits(64'(a), 3);
        en = 1'b0; wait_n(4);
        pulse(1'b0);
        d = '0;
        for (int i = 0; i < 32; i++) begin
            pulse(1'b0);
            d = {d[30:0], sdo};
        end
        wait_n(4);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 ready", 32'(rdy), 32'd1);
        chk("R1 sdo", 32'(sdo), 32'd0);
        for (int a = 0; a < 8; a++) begin
            reg_read(3'(a), d);
            chk("R1 reg", d, 32'd0);
            model[a] = '0;
        end
    endtask

    task automatic t_write_read;
        logic [31:0] d;
        reg_write(3'd5, 32'h8000_0001);
        reg_write(3'd7, 32'hDEAD_BEEF);
        reg_write(3'd1, 32'h0123_4567);
        reg_write(3'd0, 32'h0000_0064);
        reg_read(3'd5, d); chk("R2/R3 reg5", d, model[5]);
        reg_read(3'd7, d); chk("R2/R3 reg7", d, model[7]);
        reg_read(3'd1, d); chk("R2/R3 reg1", d, model[1]);
        reg_read(3'd0, d); chk("R2 counter set", d, model[0]);
        reg_read(3'd3, d); chk("R2 untouched reg3", d, 32'd0);
    endtask

    task automatic t_ready;
        logic [31:0] d;
        en = 1'b1; wait_n(6);
        chk("R7 busy after enable", 32'(rdy), 32'd0);
        send_bits(64'({32'hCAFE_F00D, 3'd2}), 35);
        chk("R7 busy mid write", 32'(rdy), 32'd0);
        en = 1'b0; wait_n(4);
        pulse(1'b1); sdi = 1'b0; wait_n(4);
        model[2] = 32'hCAFE_F00D;
        chk("R7 ready after write", 32'(rdy), 32'd1);
        en = 1'b1; wait_n(6);
        send_bits(64'(3'd2), 3);
        en = 1'b0; wait_n(4);
        pulse(1'b0);
        d = '0;
        for (int i = 0; i < 32; i++) begin
            pulse(1'b0);
            d = {d[30:0], sdo};
            if (i == 15) chk("R7 busy mid read", 32'(rdy), 32'd0);
        end
        chk("R7 ready after 32 bits", 32'(rdy), 32'd1);
        chk("R3 read data", d, model[2]);
    endtask

    task automatic t_idle_ignore;
        logic [31:0] d;
        en = 1'b0;
        send_bits(64'hFFFF_FFFF_FFFF_FFFF, 40);
        chk("R4 ready stays", 32'(rdy), 32'd1);
        reg_read(3'd7, d); chk("R4 reg7 unchanged", d, model[7]);
    endtask

    task automatic t_short;
        logic [31:0] d;
        write_frame(64'({17'h1ABCD, 3'd5}), 20);
        chk("R5 ready after short", 32'(rdy), 32'd1);
        reg_read(3'd5, d); chk("R5 no commit", d, model[5]);
    endtask

    task automatic t_long;
        logic [31:0] d;
        write_frame(64'({5'b10110, 32'h1357_9BDF, 3'd6}), 40);
        model[6] = 32'h1357_9BDF;
        reg_read(3'd6, d); chk("R6 last 35 bits", d, model[6]);
    endtask

    task automatic t_abort;
        logic [31:0] d;
        en = 1'b1; wait_n(6);
        send_bits(64'({32'h7777_7777, 3'd2}), 35);
        rrst = 1'b1; wait_n(1); rrst = 1'b0; wait_n(1);
        chk("R8 ready after abort", 32'(rdy), 32'd1);
        en = 1'b0; wait_n(4);
        pulse(1'b1); sdi = 1'b0; wait_n(4);
        reg_read(3'd2, d); chk("R8 aborted write", d, model[2]);
        en = 1'b1; wait_n(6);
        send_bits(64'(3'd7), 3);
        en = 1'b0; wait_n(4);
        pulse(1'b0);
        for (int i = 0; i < 3; i++) pulse(1'b0);
        rrst = 1'b1; wait_n(1); rrst = 1'b0; wait_n(1);
        chk("R8 sdo cleared", 32'(sdo), 32'd0);
        chk("R8 ready after read abort", 32'(rdy), 32'd1);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; wait_n(1); tick = 1'b0; wait_n(3);
        end
    endtask

    task automatic t_tick;
        logic [31:0] d;
        reg_write(3'd0, 32'd100);
        tick_n(5);
        reg_read(3'd0, d); chk("R9 five ticks", d, 32'd105);
        reg_write(3'd0, 32'hFFFF_FFFF);
        tick_n(1);
        reg_read(3'd0, d); chk("R9 wrap", d, 32'd0);
    endtask

    task automatic t_collide;
        logic [31:0] d, w, e;
        for (int k = 0; k < 6; k++) begin
            reg_write(3'd0, 32'h0000_1000);
            w = 32'h5A5A_0000 + 32'(k);
            en = 1'b1; wait_n(6);
            send_bits(64'({w, 3'd0}), 35);
            en = 1'b0; wait_n(4);
            sdi = 1'b1; wait_n(4);
            sclk = 1'b1;
            for (int i = 0; i < 6; i++) begin
                if (i == k) tick = 1'b1;
                wait_n(1);
                tick = 1'b0;
            end
            sclk = 1'b0; wait_n(6);
            sdi = 1'b0; wait_n(4);
            reg_read(3'd0, d);
            e = (d == w + 32'd1) ? w + 32'd1 : w;
            chk("R10 write vs tick", d, e);
        end
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);
        t_reset();
        t_write_read();
        t_ready();
        t_idle_ignore();
        t_short();
        t_long();
        t_abort();
        t_tick();
        t_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule